// File: doc/BRIEF.md
# Decimal Nibble Rotate Unit

This block performs a 12-bit rotation by one nibble across two places: the low nibble of an accumulator and the two nibbles of a byte held in memory. The rotation runs either left or right. The high nibble of the accumulator takes no part in it. A processor core hands over the accumulator, the incoming carry, a 16-bit pointer and the direction, then pulses `start`. The unit reads the addressed byte through a simple synchronous memory port and writes the rotated byte back to the same address. It then presents the new accumulator and a fresh flag byte together with a one-cycle `done` pulse.

Each operation runs as a fixed sequence of four states: idle, read, write and done. The read phase waits as long as the memory takes to answer. The write phase and the done phase each last exactly one clock. While the unit is busy, further start pulses are dropped. With each completed operation the unit also reports the instruction cost in clocks, so that the core can account for time.

Top module: `nibble_rot_unit`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are 0, and `acc_out`, `flags_out` and `op_cycles` are all zero.
- R2: A `start` seen while idle makes `mem_rd_en` 1 from the next cycle with `mem_addr` equal to the `ptr` sampled with `start`. `mem_rd_en` stays 1 until a cycle in which `mem_rd_valid` is 1.
- R3: With `dir_left`=0 (rotate right), the written byte is {old accumulator low nibble, old memory high nibble} and `acc_out` is {old accumulator high nibble, old memory low nibble}.
- R4: With `dir_left`=1 (rotate left), the written byte is {old memory low nibble, old accumulator low nibble} and `acc_out` is {old accumulator high nibble, old memory high nibble}.
- R5: `mem_wr_en` is 1 for exactly one cycle, namely the cycle after the read is accepted. During that cycle `mem_rd_en` is 0 and `mem_addr` still holds the pointer.
- R6: `done` is 1 for exactly one cycle, the cycle after the write. `acc_out` and `flags_out` take their new values in that cycle and hold them until the next operation completes.
- R7: Flag bit 0 (carry) equals the sampled `carry_in`. Flag bits 4 (half-carry) and 1 (subtract) are 0.
- R8: Flag bit 7 equals `acc_out[7]`. Bit 6 is 1 exactly when `acc_out` is 0. Bit 2 is 1 when `acc_out` has an even number of ones. Bits 5 and 3 copy `acc_out[5]` and `acc_out[3]`.
- R9: `op_cycles` reads 18 from the cycle in which `done` is first 1.
- R10: A `start` that arrives while `busy` is 1, including the read-wait cycles and the done cycle, starts no new read and does not change the operands of the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dir_left | input | 1 | 1 = rotate left, 0 = rotate right |
| acc_in | input | 8 | Accumulator value at start |
| carry_in | input | 1 | Carry flag at start |
| ptr | input | 16 | Memory pointer at start |
| mem_addr | output | 16 | Memory address |
| mem_rd_en | output | 1 | Read request, held until answered |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 8 | Read data |
| mem_wr_en | output | 1 | One-cycle write strobe |
| mem_wr_data | output | 8 | Rotated byte to write |
| acc_out | output | 8 | New accumulator |
| flags_out | output | 8 | New flag byte |
| op_cycles | output | 5 | Reported instruction cost |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle: a new `start` and the unit's own read answer or done cycle. The bench raises `start` with different operands during read-wait cycles and during the done cycle. It then checks that exactly one write happens, that the written byte and new accumulator come from the first operands, and that no read request follows the done cycle. Random operands, directions and memory latencies are mixed with directed zero-result, parity and carry cases, and each is compared against values computed from the requirements.

// File: rtl/nrot_pkg.sv
package nrot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } nrot_state_e;

  // Flag byte layout; a consumer decodes these positions.
  localparam int FB_CARRY = 0;
  localparam int FB_SUB   = 1;
  localparam int FB_PAR   = 2;
  localparam int FB_CPY3  = 3;
  localparam int FB_HALF  = 4;
  localparam int FB_CPY5  = 5;
  localparam int FB_ZERO  = 6;
  localparam int FB_SIGN  = 7;
  localparam int FLAG_W   = 8;

endpackage

// File: rtl/nrot_seq.sv
module nrot_seq
  import nrot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        rd_valid,
  output nrot_state_e state,
  output logic        take_start,
  output logic        take_read
);

  nrot_state_e st_q, st_d;

  assign take_start = (st_q == ST_IDLE) && start;
  assign take_read  = (st_q == ST_READ) && rd_valid;
  assign state      = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start)    st_d = ST_READ;
      ST_READ:  if (rd_valid) st_d = ST_WRITE;
      ST_WRITE:               st_d = ST_DONE;
      ST_DONE:                st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/nrot_shuffle.sv
module nrot_shuffle #(
  parameter int NIB_W = 4,
  localparam int DATA_W = 2 * NIB_W
) (
  input  logic              dir_left,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mem,
  output logic [DATA_W-1:0] new_mem,
  output logic [DATA_W-1:0] new_acc
);

  logic [NIB_W-1:0] acc_hi, acc_lo, mem_hi, mem_lo;

  assign acc_hi = acc[DATA_W-1:NIB_W];
  assign acc_lo = acc[NIB_W-1:0];
  assign mem_hi = mem[DATA_W-1:NIB_W];
  assign mem_lo = mem[NIB_W-1:0];

  always_comb begin
    if (dir_left) begin
      new_mem = {mem_lo, acc_lo};
      new_acc = {acc_hi, mem_hi};
    end else begin
      new_mem = {acc_lo, mem_hi};
      new_acc = {acc_hi, mem_lo};
    end
  end

endmodule

// File: rtl/nrot_flaggen.sv
module nrot_flaggen
  import nrot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              carry,
  input  logic [DATA_W-1:0] acc,
  output logic [FLAG_W-1:0] flags
);

  // Parity fold: stage k holds XOR of bits 0..k.
  logic [DATA_W-1:0] fold;

  assign fold[0] = acc[0];
  for (genvar k = 1; k < DATA_W; k++) begin : g_fold
    assign fold[k] = fold[k-1] ^ acc[k];
  end

  always_comb begin
    flags           = '0;
    flags[FB_CARRY] = carry;
    flags[FB_SUB]   = 1'b0;
    flags[FB_HALF]  = 1'b0;
    flags[FB_PAR]   = ~fold[DATA_W-1];
    flags[FB_ZERO]  = (acc == '0);
    flags[FB_SIGN]  = acc[DATA_W-1];
    flags[FB_CPY5]  = acc[5];
    flags[FB_CPY3]  = acc[3];
  end

endmodule

// File: rtl/nibble_rot_unit.sv
module nibble_rot_unit
  import nrot_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 16,
  parameter int COST   = 18,
  localparam int DATA_W = 2 * NIB_W,
  localparam int COST_W = $clog2(COST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_left,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              carry_in,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [DATA_W-1:0] acc_out,
  output logic [FLAG_W-1:0] flags_out,
  output logic [COST_W-1:0] op_cycles,
  output logic              busy,
  output logic              done
);

  nrot_state_e state;
  logic        take_start, take_read;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] acc_q, nacc_q, wdata_q, accout_q;
  logic              carry_q, dir_q, rd_q, wr_q, done_q;
  logic [FLAG_W-1:0] flags_q;
  logic [COST_W-1:0] cost_q;

  logic [DATA_W-1:0] new_mem_w, new_acc_w;
  logic [FLAG_W-1:0] flag_w;

  nrot_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .rd_valid   (mem_rd_valid),
    .state      (state),
    .take_start (take_start),
    .take_read  (take_read)
  );

  nrot_shuffle #(.NIB_W(NIB_W)) u_shuf (
    .dir_left (dir_q),
    .acc      (acc_q),
    .mem      (mem_rd_data),
    .new_mem  (new_mem_w),
    .new_acc  (new_acc_w)
  );

  nrot_flaggen #(.DATA_W(DATA_W)) u_flag (
    .carry (carry_q),
    .acc   (nacc_q),
    .flags (flag_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      acc_q    <= '0;
      nacc_q   <= '0;
      wdata_q  <= '0;
      accout_q <= '0;
      carry_q  <= 1'b0;
      dir_q    <= 1'b0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      done_q   <= 1'b0;
      flags_q  <= '0;
      cost_q   <= '0;
    end else begin
      if (take_start) begin
        addr_q  <= ptr;
        acc_q   <= acc_in;
        carry_q <= carry_in;
        dir_q   <= dir_left;
        rd_q    <= 1'b1;
      end
      if (take_read) begin
        rd_q    <= 1'b0;
        wr_q    <= 1'b1;
        wdata_q <= new_mem_w;
        nacc_q  <= new_acc_w;
      end
      if (state == ST_WRITE) begin
        wr_q     <= 1'b0;
        done_q   <= 1'b1;
        accout_q <= nacc_q;
        flags_q  <= flag_w;
        cost_q   <= COST_W'(COST);
      end
      if (state == ST_DONE) begin
        done_q <= 1'b0;
      end
    end
  end

  assign mem_addr    = addr_q;
  assign mem_rd_en   = rd_q;
  assign mem_wr_en   = wr_q;
  assign mem_wr_data = wdata_q;
  assign acc_out     = accout_q;
  assign flags_out   = flags_q;
  assign op_cycles   = cost_q;
  assign done        = done_q;
  assign busy        = (state != ST_IDLE);

endmodule

// File: rtl/nrot_chk.sv
module nrot_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  parameter int COST_W = 5,
  parameter int COST   = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_rd_en,
  input logic              mem_rd_valid,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic [DATA_W-1:0] acc_out,
  input logic [FLAG_W-1:0] flags_out,
  input logic [COST_W-1:0] op_cycles
);

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !mem_rd_valid) |=> mem_rd_en);

  p_wr_follows_rd_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && mem_rd_valid) |=> (mem_wr_en && !mem_rd_en));

  p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en);

  p_wr_addr_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_addr == $past(mem_addr)));

  p_done_after_wr_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> done);

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!flags_out[4] && !flags_out[1]));

  p_flag_sign_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (flags_out[7] == acc_out[7] && flags_out[6] == (acc_out == '0)));

  p_cost_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (op_cycles == COST_W'(COST)));

  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> (!mem_rd_en && !busy));

  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd_en, mem_wr_en, done}));

endmodule

bind nibble_rot_unit nrot_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .FLAG_W (nrot_pkg::FLAG_W),
  .COST_W (COST_W),
  .COST   (COST)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .mem_rd_en    (mem_rd_en),
  .mem_rd_valid (mem_rd_valid),
  .mem_wr_en    (mem_wr_en),
  .mem_addr     (mem_addr),
  .done         (done),
  .acc_out      (acc_out),
  .flags_out    (flags_out),
  .op_cycles    (op_cycles)
);

// File: tb/tb_nibble_rot_unit.sv
module tb_nibble_rot_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dir_left = 1'b0;
  logic [7:0]  acc_in = '0;
  logic        carry_in = 1'b0;
  logic [15:0] ptr = '0;
  logic [15:0] mem_addr;
  logic        mem_rd_en;
  logic        mem_rd_valid = 1'b0;
  logic [7:0]  mem_rd_data = '0;
  logic        mem_wr_en;
  logic [7:0]  mem_wr_data;
  logic [7:0]  acc_out;
  logic [7:0]  flags_out;
  logic [4:0]  op_cycles;
  logic        busy;
  logic        done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nibble_rot_unit dut (
    .clk(clk), .rst(rst), .start(start), .dir_left(dir_left),
    .acc_in(acc_in), .carry_in(carry_in), .ptr(ptr),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
    .acc_out(acc_out), .flags_out(flags_out), .op_cycles(op_cycles),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mem(input bit left, input logic [7:0] a,
                                         input logic [7:0] m);
    return left ? {m[3:0], a[3:0]} : {a[3:0], m[7:4]};
  endfunction

  function automatic logic [7:0] exp_acc(input bit left, input logic [7:0] a,
                                         input logic [7:0] m);
    return left ? {a[7:4], m[7:4]} : {a[7:4], m[3:0]};
  endfunction

  function automatic logic [7:0] exp_flags(input logic [7:0] a, input bit c);
    logic [7:0] f;
    int ones;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += a[i];
    f = 8'h00;
    f[0] = c;
    f[2] = (ones % 2 == 0);
    f[3] = a[3];
    f[5] = a[5];
    f[6] = (a == 8'h00);
    f[7] = a[7];
    return f;
  endfunction

  // One full operation. wait_n: extra read-wait cycles; poke: raise start while busy.
  task automatic run_op(input bit left, input logic [7:0] a, input bit c,
                        input logic [15:0] p, input logic [7:0] m,
                        input int wait_n, input bit poke);
    logic [7:0] ea, ef;
    ea = exp_acc(left, a, m);
    ef = exp_flags(ea, c);
    @(negedge clk);
    start = 1'b1; dir_left = left; acc_in = a; carry_in = c; ptr = p;
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd_en === 1'b1, "R2 rd_en", {31'd0, mem_rd_en}, 1);
    chk(mem_addr === p, "R2 addr", mem_addr, p);
    for (int i = 0; i < wait_n; i++) begin
      if (poke) begin
        start = 1'b1; acc_in = ~a; ptr = ~p; dir_left = ~left; carry_in = ~c;
      end
      @(negedge clk);
      start = 1'b0;
      chk(mem_rd_en === 1'b1 && mem_wr_en === 1'b0, "R2 hold/R10",
          {30'd0, mem_rd_en, mem_wr_en}, 2);
      chk(mem_addr === p, "R10 addr kept", mem_addr, p);
    end
    mem_rd_valid = 1'b1; mem_rd_data = m;
    @(negedge clk);
    mem_rd_valid = 1'b0; mem_rd_data = 8'hxx;
    chk(mem_wr_en === 1'b1 && mem_rd_en === 1'b0, "R5 strobe",
        {30'd0, mem_wr_en, mem_rd_en}, 2);
    chk(mem_addr === p, "R5 addr", mem_addr, p);
    chk(mem_wr_data === exp_mem(left, a, m), left ? "R4 wr_data" : "R3 wr_data",
        mem_wr_data, exp_mem(left, a, m));
    @(negedge clk);
    chk(mem_wr_en === 1'b0 && done === 1'b1, "R6 done",
        {30'd0, mem_wr_en, done}, 1);
    chk(acc_out === ea, left ? "R4 acc" : "R3 acc", acc_out, ea);
    chk(flags_out[0] === c && flags_out[4] === 1'b0 && flags_out[1] === 1'b0,
        "R7 flags", flags_out, ef);
    chk(flags_out === ef, "R8 flags", flags_out, ef);
    chk(op_cycles === 5'd18, "R9 cost", op_cycles, 18);
    if (poke) begin
      start = 1'b1; acc_in = ~a; ptr = ~p;
    end
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b0 && busy === 1'b0 && mem_rd_en === 1'b0, "R10 done-cycle start",
        {29'd0, done, busy, mem_rd_en}, 0);
    chk(acc_out === ea && flags_out === ef, "R6 hold", {acc_out, flags_out}, {ea, ef});
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_rd_en === 1'b0 && mem_wr_en === 1'b0,
        "R1 ctrl", {28'd0, busy, done, mem_rd_en, mem_wr_en}, 0);
    chk(acc_out === 8'h00 && flags_out === 8'h00 && op_cycles === 5'd0, "R1 data",
        {acc_out, flags_out, 3'd0, op_cycles}, 0);
    rst = 1'b0;
    // Directed corners
    run_op(1'b0, 8'h05, 1'b0, 16'h1234, 8'h00, 0, 1'b0); // R3 zero result
    run_op(1'b1, 8'hF3, 1'b1, 16'hFFFF, 8'hA7, 2, 1'b1); // R4 with start pokes
    run_op(1'b0, 8'h80, 1'b1, 16'h0000, 8'hFF, 1, 1'b1); // R8 odd parity
    run_op(1'b1, 8'h2C, 1'b0, 16'h8001, 8'h08, 0, 1'b1); // R8 copy bits
    run_op(1'b1, 8'h00, 1'b1, 16'h4000, 8'h0F, 3, 1'b0); // R4 zero, carry kept R7
    // Random mix
    for (int n = 0; n < 60; n++) begin
      run_op(1'($urandom), 8'($urandom), 1'($urandom), 16'($urandom),
             8'($urandom), int'($urandom % 4), 1'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule